// File: doc/BRIEF.md
# Load/Store Address and Data Formatter

This block sits between an integer core and a byte-addressed memory that has a 32-bit data port. For each load or store it forms the effective address and moves the data between the register and memory. The address is either a base register plus a sign-extended 16-bit displacement, or the sum of a base register and an index register. It handles byte, halfword and word sizes. For loads it zero-extends or sign-extends the result, and for stores it places the data in the right byte lanes with matching byte enables. When update is requested, it returns the effective address so the core can write it into the base register.

Memory is big-endian: the lowest-addressed byte travels in bits 31:24 of the bus word. An access that stays inside one aligned word uses one bus beat. An access that crosses a word boundary uses two aligned beats, one after the other. For a load, the two beats are joined before extension.

The core offers a request with `req_valid`, and the block accepts it on a cycle where `req_ready` is high. Each accepted request produces a single-cycle `done` pulse that carries the result.

Top module: `ls_formatter`

## Requirements
- R1: In displacement mode (`req_indexed`=0) the effective address is the base value plus `disp` sign-extended to 32 bits. It is reported on `eff_addr` during `done`.
- R2: In indexed mode (`req_indexed`=1) the effective address is `base_val + index_val`.
- R3: When `base_sel` is 0, the constant 0 is used in place of `base_val`, whatever value `base_val` carries.
- R4: A load with `req_signed`=0 returns the addressed bytes right-justified on `load_data`, with every higher bit cleared. `req_size` is encoded 0 = byte, 1 = halfword, 2 = word.
- R5: A halfword load with `req_signed`=1 fills bits 31:16 of `load_data` with bit 15 of the loaded halfword.
- R6: A load with `req_signed`=1 and a byte or word size completes with `illegal` high during `done`. It makes no bus beat and leaves `wb_en` low.
- R7: With `req_update`=1 on a legal request, `wb_en` is high during `done` and `eff_addr` carries the value to write into the base register.
- R8: Big-endian lanes: the byte at address A uses bus bits [31-8*(A mod 4) -: 8]. A store writes only its own bytes, because `mem_be` bit 3 enables bits 31:24 and bit 0 enables bits 7:0.
- R9: An access that fits in one aligned word uses exactly one bus beat. An access whose bytes cross a word boundary uses two beats, at the lower word address and then at that address plus 4. Every `mem_addr` has bits 1:0 equal to 0.
- R10: A load that crosses a word boundary returns the bytes joined from both beats in address order, and only then is extension applied.
- R11: `mem_valid` stays high and `mem_addr` stays unchanged until `mem_ready` is seen. `req_ready` is low from acceptance until `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered by the core |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_signed | input | 1 | Algebraic (sign-extending) load |
| req_indexed | input | 1 | 1 = base + index, 0 = base + displacement |
| req_update | input | 1 | Write effective address back to base |
| base_sel | input | 5 | Base register number; 0 means constant zero |
| base_val | input | 32 | Base register contents |
| index_val | input | 32 | Index register contents |
| disp | input | 16 | Signed displacement |
| store_data | input | 32 | Store value, right-justified |
| mem_valid | output | 1 | Bus beat request |
| mem_ready | input | 1 | Memory accepts the beat (read data valid) |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Word-aligned beat address |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_wdata | output | 32 | Write data in lane order |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| done | output | 1 | One-cycle completion pulse |
| load_data | output | 32 | Extended load result |
| eff_addr | output | 32 | Effective address |
| wb_en | output | 1 | Base write-back strobe |
| illegal | output | 1 | Rejected algebraic form |

## Verification
The base write-back and the load result arrive in the same `done` cycle. The hardest case pairs update mode with an access that crosses a word boundary, so the write-back address has to survive two bus beats while the joined data is being formed. The bench provokes this with a misaligned update store and with update loads. A scoreboard item holds the expected data, address, write-back strobe and beat count for each request, and all of them are compared against the single `done` pulse. The memory model stalls `mem_ready` on alternate cycles so that the held beats are exercised too.

// File: rtl/ls_formatter.sv
module ls_formatter (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_signed,
  input  logic        req_indexed,
  input  logic        req_update,
  input  logic [4:0]  base_sel,
  input  logic [31:0] base_val,
  input  logic [31:0] index_val,
  input  logic [15:0] disp,
  input  logic [31:0] store_data,
  output logic        mem_valid,
  input  logic        mem_ready,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic        done,
  output logic [31:0] load_data,
  output logic [31:0] eff_addr,
  output logic        wb_en,
  output logic        illegal
);
  typedef enum logic [1:0] {S_IDLE, S_B0, S_B1, S_FIN} st_t;
  st_t st;

  logic [31:0] ea_q, sdata_q, hi_q, res_q;
  logic [2:0]  nb_q;
  logic        sgn_q, store_q, upd_q, ill_q;

  wire [31:0] base_eff = (base_sel == 5'd0) ? 32'd0 : base_val;
  wire [31:0] offs     = req_indexed ? index_val : {{16{disp[15]}}, disp};
  wire [31:0] ea_c     = base_eff + offs;
  wire [2:0]  nb_c     = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;
  wire        ill_c    = !req_store && req_signed && (nb_c != 3'd2);

  wire [1:0]  off   = ea_q[1:0];
  wire        split = ({1'b0, off} + nb_q) > 3'd4;
  wire [5:0]  rsh   = 6'd32 - {nb_q, 3'b000};
  wire [31:0] top   = sdata_q << rsh;
  wire [63:0] win   = {top, 32'd0} >> {off, 3'b000};
  wire [7:0]  mask  = (~(8'hFF >> nb_q)) >> off;

  wire [63:0] merged = (st == S_B1) ? {hi_q, mem_rdata} : {mem_rdata, 32'd0};
  wire [63:0] alnd   = merged << {off, 3'b000};
  wire [31:0] raw    = alnd[63:32] >> rsh;
  wire [31:0] ext    = (sgn_q && nb_q == 3'd2) ? {{16{raw[15]}}, raw[15:0]} : raw;

  wire beat_ok = mem_valid && mem_ready;

  assign req_ready = (st == S_IDLE);
  assign mem_valid = (st == S_B0) || (st == S_B1);
  assign mem_we    = store_q;
  assign mem_addr  = {ea_q[31:2], 2'b00} + ((st == S_B1) ? 32'd4 : 32'd0);
  assign mem_be    = (st == S_B1) ? mask[3:0] : mask[7:4];
  assign mem_wdata = (st == S_B1) ? win[31:0] : win[63:32];
  assign done      = (st == S_FIN);
  assign load_data = res_q;
  assign eff_addr  = ea_q;
  assign wb_en     = done && upd_q && !ill_q;
  assign illegal   = done && ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ea_q    <= '0;
      sdata_q <= '0;
      hi_q    <= '0;
      res_q   <= '0;
      nb_q    <= 3'd1;
      sgn_q   <= 1'b0;
      store_q <= 1'b0;
      upd_q   <= 1'b0;
      ill_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q    <= ea_c;
          sdata_q <= store_data;
          nb_q    <= nb_c;
          sgn_q   <= req_signed;
          store_q <= req_store;
          upd_q   <= req_update;
          ill_q   <= ill_c;
          res_q   <= '0;
          st      <= ill_c ? S_FIN : S_B0;
        end
        S_B0: if (beat_ok) begin
          if (split) begin
            hi_q <= mem_rdata;
            st   <= S_B1;
          end else begin
            if (!store_q) res_q <= ext;
            st <= S_FIN;
          end
        end
        S_B1: if (beat_ok) begin
          if (!store_q) res_q <= ext;
          st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  // R11
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  // R9
  word_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00 && mem_be != 4'd0));
  // R9
  second_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && st == S_B0 && split) |=> (mem_addr == $past(mem_addr) + 32'd4));
  // R6
  illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wb_en);
  // R6
  illegal_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && !req_store && req_signed && req_size != 2'd1) |=> !mem_valid);
endmodule

// File: tb/ls_formatter_bench.sv
module ls_formatter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_store = 0, req_signed = 0, req_indexed = 0, req_update = 0;
  logic [1:0]  req_size = 0;
  logic [4:0]  base_sel = 0;
  logic [31:0] base_val = 0, index_val = 0, store_data = 0;
  logic [15:0] disp = 0;
  logic        req_ready, mem_valid, mem_we, done, wb_en, illegal;
  logic        mem_ready = 0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, load_data, eff_addr;
  logic [3:0]  mem_be;

  ls_formatter u_ls_formatter (.*);

  typedef struct {
    string       tag;
    logic        is_load;
    logic [31:0] data;
    logic [31:0] ea;
    logic        wb;
    logic        ill;
    int          beats;
  } item_t;
  item_t q[$];

  int checks = 0, errors = 0;
  logic [7:0] mem_b [64];
  logic [7:0] ref_b [64];
  int beat_total = 0, beat_seen = 0;
  logic stall = 0;

  initial for (int i = 0; i < 64; i++) begin
    mem_b[i] = 8'(i * 7 + 3);
    ref_b[i] = 8'(i * 7 + 3);
  end

  wire [3:0] wa = mem_addr[5:2];
  assign mem_rdata = {mem_b[{wa, 2'd0}], mem_b[{wa, 2'd1}], mem_b[{wa, 2'd2}], mem_b[{wa, 2'd3}]};

  always @(negedge clk) begin
    stall = ~stall;
    mem_ready = mem_valid && !stall;
  end

  always @(posedge clk) if (rst_n && mem_valid && mem_ready) begin
    beat_total++;
    if (mem_we) for (int k = 0; k < 4; k++)
      if (mem_be[3-k]) mem_b[{wa, 2'(k)}] = mem_wdata[31-8*k -: 8];
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    item_t it;
    int nb;
    nb = beat_total - beat_seen;
    beat_seen = beat_total;
    if (q.size() == 0) begin
      check("spurious done", 32'd1, 32'd0);
    end else begin
      it = q.pop_front();
      check({it.tag, " illegal"}, {31'd0, illegal}, {31'd0, it.ill});
      check({it.tag, " beats"}, nb, it.beats);
      check({it.tag, " wb_en"}, {31'd0, wb_en}, {31'd0, it.wb});
      if (!it.ill) check({it.tag, " eff_addr"}, eff_addr, it.ea);
      if (it.is_load && !it.ill) check({it.tag, " load_data"}, load_data, it.data);
    end
  end

  task automatic op(string tag, bit st, int sz, bit sg, bit idx, bit upd,
                    logic [4:0] sel, logic [31:0] b, logic [31:0] ix, logic [15:0] d, logic [31:0] sd);
    item_t it;
    logic [31:0] ea, v;
    int n;
    n  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    ea = ((sel == 0) ? 32'd0 : b) + (idx ? ix : {{16{d[15]}}, d});
    it.tag = tag; it.is_load = !st; it.ea = ea;
    it.ill = !st && sg && sz != 1;
    it.wb = upd && !it.ill;
    it.beats = it.ill ? 0 : ((ea[1:0] + n > 4) ? 2 : 1);
    v = 0;
    for (int k = 0; k < n; k++) v = (v << 8) | 32'(ref_b[6'(ea + k)]);
    if (sg && n == 2) v = {{16{v[15]}}, v[15:0]};
    it.data = v;
    if (st && !it.ill) for (int k = 0; k < n; k++) ref_b[6'(ea + k)] = sd[8*(n-1-k) +: 8];
    q.push_back(it);
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = 2'(sz); req_signed = sg; req_indexed = idx;
    req_update = upd; base_sel = sel; base_val = b; index_val = ix; disp = d; store_data = sd;
    @(negedge clk);
    req_valid = 0;
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("reset req_ready", {31'd0, req_ready}, 32'd1);
    check("reset mem_valid", {31'd0, mem_valid}, 32'd0);
    check("reset done", {31'd0, done}, 32'd0);
    op("R1 R9 word disp", 0, 2, 0, 0, 0, 5'd3, 32'd16, 32'd0, 16'd4, 32'd0);
    op("R5 signed half negdisp", 0, 1, 1, 0, 0, 5'd2, 32'd40, 32'd0, -16'sd6, 32'd0);
    op("R4 zero half", 0, 1, 0, 0, 0, 5'd2, 32'd40, 32'd0, -16'sd6, 32'd0);
    op("R2 R4 byte indexed", 0, 0, 0, 1, 0, 5'd4, 32'd10, 32'd5, 16'd0, 32'd0);
    op("R3 zero base", 0, 2, 0, 0, 0, 5'd0, 32'd1000, 32'd0, 16'd12, 32'd0);
    op("R6 signed byte", 0, 0, 1, 0, 1, 5'd6, 32'd8, 32'd0, 16'd1, 32'd0);
    op("R6 signed word", 0, 2, 1, 0, 0, 5'd6, 32'd8, 32'd0, 16'd0, 32'd0);
    op("R7 update load", 0, 2, 0, 0, 1, 5'd5, 32'd8, 32'd0, 16'd4, 32'd0);
    op("R8 store byte", 1, 0, 0, 0, 0, 5'd1, 32'd21, 32'd0, 16'd0, 32'h000000AB);
    op("R8 readback", 0, 2, 0, 0, 0, 5'd1, 32'd20, 32'd0, 16'd0, 32'd0);
    op("R9 split store half", 1, 1, 0, 0, 0, 5'd1, 32'd23, 32'd0, 16'd0, 32'h00001234);
    op("R8 readback lo", 0, 2, 0, 0, 0, 5'd1, 32'd20, 32'd0, 16'd0, 32'd0);
    op("R8 readback hi", 0, 2, 0, 0, 0, 5'd1, 32'd24, 32'd0, 16'd0, 32'd0);
    op("R10 split word load", 0, 2, 0, 1, 0, 5'd7, 32'd26, 32'd4, 16'd0, 32'd0);
    op("R10 R5 split signed half", 0, 1, 1, 0, 0, 5'd7, 32'd19, 32'd0, 16'd0, 32'd0);
    op("R7 R9 split update store", 1, 2, 0, 0, 1, 5'd9, 32'd40, 32'd0, 16'd5, 32'hCAFEF00D);
    op("R8 readback 44", 0, 2, 0, 0, 0, 5'd1, 32'd44, 32'd0, 16'd0, 32'd0);
    op("R8 readback 48", 0, 2, 0, 0, 0, 5'd1, 32'd48, 32'd0, 16'd0, 32'd0);
    op("R4 byte lane 3", 0, 0, 0, 0, 0, 5'd1, 32'd47, 32'd0, 16'd0, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule